// File: doc/BRIEF.md
# Masked-window GPIO with per-pin interrupt sensing

This block is an eight-pin general-purpose I/O port on a simple word-addressed register bus whose data path is one pin wide per bit. Every pin has its own direction bit. Pin values are reached through a data window in which the address itself carries a per-pin mask. A single write can update any subset of the outputs without a read-modify-write. A read returns only the pins whose mask bit is set.

Every pin can raise an interrupt. The trigger is chosen per pin: high level, low level, rising edge, falling edge, or either edge. Pin inputs are first passed through a two-flop synchroniser. Edge events latch into a raw status bit until software clears them by writing ones. Level events follow the pin directly. An enable register gates the raw status into a masked status, and a single interrupt line is the OR of the masked bits.

Top module: `gpx_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0), `pin_out` is 0, all configuration registers read 0 and `irq_out` is low.
- R2: The direction register at byte offset 0x400 sets one bit per pin, where 1 means output. It drives `pin_oe` and reads back as written.
- R3: Accesses with byte-address bits [11:10] = 00 reach the data window, and address bits [9:2] form a pin mask. A write changes only those output values whose mask bit is 1 and whose pin is an output.
- R4: A data write to a pin configured as input is ignored. When that pin later becomes an output, it drives the value it held before that write.
- R5: A data-window read returns 0 for pins with mask bit 0. For pins with mask bit 1, it returns the driven value for outputs and the synchronised pin level for inputs.
- R6: Pin inputs pass through two flops. A change is not visible one clock edge after it occurs and is visible after the second edge.
- R7: A 1 in the sense register (0x404) selects level detection. The pin's raw status then follows the synchronised level: high when the event bit (0x40C) is 1, low when it is 0. Clearing has no effect while that level persists.
- R8: With sense 0 and the both-edges bit 0, a rising edge (event bit 1) or a falling edge (event bit 0) sets a latched raw status bit that stays set until it is cleared.
- R9: A 1 in the both-edges register (0x408) makes an edge-sensed pin latch on either edge, whatever its event bit is.
- R10: Writing 1 to a bit of the clear register (0x41C) clears that pin's latched edge status. Writing 0 has no effect, and the register reads 0.
- R11: The raw status at 0x414 is read-only and ignores writes. The masked status at 0x418 equals raw status AND the enable register (0x410).
- R12: `irq_out` is high exactly when any masked status bit is 1.
- R13: Reads of undefined offsets, of offsets with address bits [1:0] not equal to 00, or of the regions where bits [11:10] are 10 or 11, return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a latched edge status that has to survive a later opposite edge, a zero clear and the clear of a neighbouring pin, while a sibling pin configured for the other polarity must stay quiet. The stimulus drives pin levels, waits past the synchroniser and the edge flop, and reads the raw register between steps. The level-versus-clear conflict is reached by holding a level-sensed pin active while writing its clear bit. Synchroniser depth is probed by keeping a data-window read open across two clock edges after a pin change.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [2:0] {
    CFG_DIR   = 3'd0,
    CFG_SENSE = 3'd1,
    CFG_BOTH  = 3'd2,
    CFG_EVT   = 3'd3,
    CFG_EN    = 3'd4,
    CFG_RAW   = 3'd5,
    CFG_MSK   = 3'd6,
    CFG_CLR   = 3'd7
  } cfg_e;

  // next output value of one pin after a data-window write
  function automatic logic win_bit_next(logic old, logic d, logic m, logic is_out);
    return (m && is_out) ? d : old;
  endfunction

  // read value of one pin through the data window
  function automatic logic win_bit_read(logic outv, logic inv, logic m, logic is_out);
    return m && (is_out ? outv : inv);
  endfunction

  // edge event selection for one pin
  function automatic logic edge_bit(logic rise, logic fall, logic both, logic evt);
    if (both) return rise || fall;
    return evt ? rise : fall;
  endfunction

  // level event for one pin: active when level equals the event polarity
  function automatic logic level_bit(logic lvl, logic evt);
    return lvl == evt;
  endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_irq_detect.sv
module gpx_irq_detect
  import gpx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] hit,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= lvl;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall;
      assign rise   = lvl[i] & ~prev_q[i];
      assign fall   = ~lvl[i] & prev_q[i];
      assign hit[i] = edge_bit(rise, fall, both[i], evt[i]);

      // a new event wins over a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q[i] <= 1'b0;
        else latch_q[i] <= (latch_q[i] & ~clr[i]) | hit[i];
      end

      assign raw[i] = sense[i] ? level_bit(lvl[i], evt[i]) : latch_q[i];
    end
  endgenerate
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  raw_stat,
  input  logic [W-1:0]  lvl,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  sense_q,
  output logic [W-1:0]  both_q,
  output logic [W-1:0]  evt_q,
  output logic [W-1:0]  en_q,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  clr_pulse
);
  localparam int MLO = 2;
  localparam int MHI = MLO + W - 1;
  localparam int RW  = AW - MHI - 1;

  logic [RW-1:0] region;
  logic [W-1:0]  amask;
  logic          aligned, is_win, is_cfg, do_wr, do_rd;
  cfg_e          idx;
  logic [W-1:0]  win_rd;

  assign region  = bus_addr[AW-1:MHI+1];
  assign amask   = bus_addr[MHI:MLO];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign is_win  = aligned && (region == '0);
  assign is_cfg  = aligned && (region == RW'(1)) && (amask[W-1:3] == '0);
  assign idx     = cfg_e'(amask[2:0]);
  assign do_wr   = bus_sel && bus_wr;
  assign do_rd   = bus_sel && !bus_wr;

  assign clr_pulse = (do_wr && is_cfg && idx == CFG_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      en_q    <= '0;
    end else if (do_wr && is_cfg) begin
      case (idx)
        CFG_DIR:   dir_q   <= bus_wdata;
        CFG_SENSE: sense_q <= bus_wdata;
        CFG_BOTH:  both_q  <= bus_wdata;
        CFG_EVT:   evt_q   <= bus_wdata;
        CFG_EN:    en_q    <= bus_wdata;
        default:   ;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q[i] <= 1'b0;
        else if (do_wr && is_win)
          out_q[i] <= win_bit_next(out_q[i], bus_wdata[i], amask[i], dir_q[i]);
      end
      assign win_rd[i] = win_bit_read(out_q[i], lvl[i], amask[i], dir_q[i]);
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (do_rd && is_win) begin
      bus_rdata = win_rd;
    end else if (do_rd && is_cfg) begin
      case (idx)
        CFG_DIR:   bus_rdata = dir_q;
        CFG_SENSE: bus_rdata = sense_q;
        CFG_BOTH:  bus_rdata = both_q;
        CFG_EVT:   bus_rdata = evt_q;
        CFG_EN:    bus_rdata = en_q;
        CFG_RAW:   bus_rdata = raw_stat;
        CFG_MSK:   bus_rdata = raw_stat & en_q;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
  parameter int W  = 8,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq_out
);
  logic [W-1:0] pin_lvl;
  logic [W-1:0] cfg_dir, cfg_sense, cfg_both, cfg_evt, cfg_en;
  logic [W-1:0] out_val, clr_pulse, edge_hit, raw_stat;

  gpx_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_lvl)
  );

  gpx_irq_detect #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .sense(cfg_sense),
    .both(cfg_both), .evt(cfg_evt), .clr(clr_pulse),
    .hit(edge_hit), .raw(raw_stat)
  );

  gpx_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_stat(raw_stat),
    .lvl(pin_lvl), .bus_rdata(bus_rdata), .dir_q(cfg_dir),
    .sense_q(cfg_sense), .both_q(cfg_both), .evt_q(cfg_evt),
    .en_q(cfg_en), .out_q(out_val), .clr_pulse(clr_pulse)
  );

  assign pin_out = out_val;
  assign pin_oe  = cfg_dir;
  assign irq_out = |(raw_stat & cfg_en);
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] edge_hit,
  input logic [W-1:0] clr_pulse,
  input logic [W-1:0] raw_stat,
  input logic [W-1:0] cfg_sense,
  input logic [W-1:0] cfg_en,
  input logic         irq_out
);
  assert_reset_inputs_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_oe == '0 && !irq_out));

  assert_input_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

  assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_hit) & ~$past(cfg_sense) & ~cfg_sense & ~raw_stat) == '0);

  assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_stat) & ~$past(clr_pulse) & ~$past(cfg_sense) & ~cfg_sense & ~raw_stat) == '0);

  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_pulse) & ~$past(edge_hit) & ~$past(cfg_sense) & ~cfg_sense & raw_stat) == '0);

  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en == '0) |-> !irq_out);
endmodule

bind gpx_port gpx_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_oe(pin_oe),
  .edge_hit(edge_hit), .clr_pulse(clr_pulse), .raw_stat(raw_stat),
  .cfg_sense(cfg_sense), .cfg_en(cfg_en), .irq_out(irq_out)
);

// File: tb/sim_gpx_port.sv
module sim_gpx_port;
  localparam int CLK_P = 10;
  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_EVT = 12'h40C, A_EN = 12'h410, A_RAW = 12'h414,
                          A_MSK = 12'h418, A_CLR = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [7:0]  pin_in = '0, pin_out, pin_oe;
  logic        irq_out;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpx_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // window address from a pin mask: mask sits in byte-address bits [9:2]
  function automatic logic [11:0] win(logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #(CLK_P/4);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    settle(4);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    #(CLK_P/4);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq_out", {7'b0, irq_out}, 8'h00);
    rd(A_DIR, d);   chk("R1 dir", d, 8'h00);
    rd(A_SENSE, d); chk("R1 sense", d, 8'h00);
    rd(A_EN, d);    chk("R1 enable", d, 8'h00);
  endtask

  task automatic t_data_write();
    logic [7:0] d;
    wr(A_DIR, 8'hF0);
    #(CLK_P/4);
    chk("R2 pin_oe", pin_oe, 8'hF0);
    rd(A_DIR, d); chk("R2 dir readback", d, 8'hF0);
    wr(win(8'hFF), 8'hA5);
    chk("R3 full-mask write", pin_out, 8'hA0);
    wr(win(8'h30), 8'h00);
    chk("R3 partial-mask write", pin_out, 8'h80);
    wr(win(8'hFF), 8'hFF);
    chk("R4 input bits ignored", pin_out, 8'hF0);
    wr(A_DIR, 8'hFF);
    #(CLK_P/4);
    chk("R4 old value after turn to output", pin_out, 8'hF0);
  endtask

  task automatic t_data_read();
    logic [7:0] d;
    wr(A_DIR, 8'hF0);
    set_pins(8'hFA);
    rd(win(8'hFF), d); chk("R5 mixed read", d, 8'hFA);
    rd(win(8'h3C), d); chk("R5 masked read", d, 8'h38);
  endtask

  task automatic t_sync();
    wr(A_DIR, 8'h00);
    set_pins(8'h00);
    @(negedge clk);
    pin_in = 8'h40;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = win(8'h40);
    @(posedge clk); #2;
    chk("R6 hidden after one edge", bus_rdata, 8'h00);
    @(posedge clk); #2;
    chk("R6 visible after two edges", bus_rdata, 8'h40);
    bus_sel = 1'b0;
    set_pins(8'h00);
    wr(A_CLR, 8'hFF);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(A_EN, 8'h01);
    wr(A_EVT, 8'h01);
    wr(A_SENSE, 8'h01);
    rd(A_RAW, d); chk("R7 level idle", d, 8'h00);
    set_pins(8'h01);
    rd(A_RAW, d); chk("R7 high level", d, 8'h01);
    chk("R12 irq on level", {7'b0, irq_out}, 8'h01);
    wr(A_CLR, 8'h01);
    rd(A_RAW, d); chk("R7 clear while level held", d, 8'h01);
    set_pins(8'h00);
    rd(A_RAW, d); chk("R7 level gone", d, 8'h00);
    chk("R12 irq low", {7'b0, irq_out}, 8'h00);
    wr(A_SENSE, 8'h03);
    rd(A_RAW, d); chk("R7 low level", d, 8'h02);
    wr(A_SENSE, 8'h00);
    wr(A_EN, 8'h00);
    wr(A_CLR, 8'hFF);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    wr(A_EVT, 8'h04);
    rd(A_RAW, d); chk("R8 edge idle", d, 8'h00);
    set_pins(8'h08);
    rd(A_RAW, d); chk("R8 rise on falling-sensed pin", d, 8'h00);
    set_pins(8'h04);
    rd(A_RAW, d); chk("R8 rise and fall caught", d, 8'h0C);
    set_pins(8'h00);
    rd(A_RAW, d); chk("R8 latched past opposite edge", d, 8'h0C);
    wr(A_CLR, 8'h04);
    rd(A_RAW, d); chk("R10 clear one bit", d, 8'h08);
    wr(A_CLR, 8'h00);
    rd(A_RAW, d); chk("R10 zero write no effect", d, 8'h08);
    rd(A_CLR, d); chk("R10 clear reads zero", d, 8'h00);
    wr(A_CLR, 8'h08);
    wr(A_RAW, 8'hFF);
    rd(A_RAW, d); chk("R11 raw ignores writes", d, 8'h00);
  endtask

  task automatic t_both();
    logic [7:0] d;
    wr(A_EVT, 8'h00);
    wr(A_BOTH, 8'h10);
    set_pins(8'h10);
    rd(A_RAW, d); chk("R9 rise despite falling event", d, 8'h10);
    wr(A_CLR, 8'h10);
    set_pins(8'h00);
    rd(A_RAW, d); chk("R9 fall caught", d, 8'h10);
    wr(A_CLR, 8'h10);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(A_BOTH, 8'h30);
    wr(A_EN, 8'h10);
    set_pins(8'h20);
    rd(A_RAW, d); chk("R11 raw set", d, 8'h20);
    rd(A_MSK, d); chk("R11 masked off", d, 8'h00);
    chk("R12 irq masked", {7'b0, irq_out}, 8'h00);
    wr(A_EN, 8'h30);
    rd(A_MSK, d); chk("R11 masked on", d, 8'h20);
    chk("R12 irq raised", {7'b0, irq_out}, 8'h01);
    wr(A_CLR, 8'h20);
    #(CLK_P/4);
    chk("R12 irq after clear", {7'b0, irq_out}, 8'h00);
  endtask

  task automatic t_undef();
    logic [7:0] d;
    wr(A_DIR, 8'h00);
    wr(12'h420, 8'hFF);
    wr(12'h800, 8'hFF);
    wr(12'h401, 8'hFF);
    rd(A_DIR, d); chk("R13 dir untouched", d, 8'h00);
    chk("R13 pin_oe untouched", pin_oe, 8'h00);
    rd(12'h420, d); chk("R13 undefined offset", d, 8'h00);
    rd(12'hC00, d); chk("R13 upper region", d, 8'h00);
    rd(12'h412, d); chk("R13 misaligned", d, 8'h00);
  endtask

  initial begin
    #(CLK_P*50000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_data_write();
    t_data_read();
    t_sync();
    t_level();
    t_edge();
    t_both();
    t_mask();
    t_undef();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule